// File: doc/BRIEF.md
# DAC Load and Clear Controller

This block decides when a bank of DAC channel codes moves from its input registers into the DAC registers that drive the converters. Software or a host port writes channel codes into the input registers at any time outside reset. A low-going load strobe then asks for all channels to be copied together. The block holds that copy back while anything keeps the shared busy line active. That includes an internal arithmetic pass, the power-on settling window, the reset input and an external agent pulling the line. A request that arrives during such a window is held and is carried out once the line frees.

A separate active-low clear input switches every channel output to its ground reference without disturbing any stored code. While clear is low it masks load requests and drops any request still waiting. The outputs stay grounded after clear is released. They return to their codes only with the next accepted load. The strobe, clear and the busy line are asynchronous pins, so each passes through a two-stage synchronizer before use.

Top module: `dac_load_ctrl`

## Requirements
- R1: A falling edge on `ldac_n` while busy is inactive gives `xfer_en` high for exactly one cycle, beginning after the third rising clock edge that samples `ldac_n` low. On the following edge every channel's `dac_code` slice (channel k at bits k*DW upward) takes the value of its input register.
- R2: A falling edge on `ldac_n` while busy is active is held, with no transfer. `xfer_en` pulses once, on the first clock edge at which busy is inactive. If `calc_busy` is the only source, that is the edge right after `calc_busy` drops.
- R3: `busy` is high whenever `calc_busy` is high, `rst_n` is low, the power-on window is running, or the synchronized `busy_line_n` is low. `busy_pull` is high only for the first three of these sources, never for the external line.
- R4: A falling edge on `ldac_n` during reset or during the POR_CYCLES-cycle power-on window after reset release is discarded. A request held when reset asserts is also lost.
- R5: While the synchronized `clr_n` is low, every bit of `gnd_sel` is 1 and `ldac_n` edges cause no transfer. A request held for busy is discarded.
- R6: After `clr_n` returns high, `gnd_sel` stays all ones until the next transfer, which sets it to all zeros on the same edge that updates `dac_code`.
- R7: Clear changes neither `dac_code` nor the input registers. Codes written during clear are the ones loaded by the first transfer after it.
- R8: A write (`wr_en` high) stores `wr_data` into input register `wr_ch` even while busy is active. A write is ignored while `rst_n` is low or when `wr_ch` is NUM_CH or higher.
- R9: During reset `xfer_en` is 0, `gnd_sel` is all zeros, every `dac_code` slice is 0, and `busy` and `busy_pull` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset; also a busy source |
| ldac_n | input | 1 | Asynchronous load strobe, falling edge requests a transfer |
| clr_n | input | 1 | Asynchronous active-low clear |
| calc_busy | input | 1 | Internal calculation in progress (same clock domain) |
| busy_line_n | input | 1 | Level of the shared open-drain busy line, low when pulled |
| wr_en | input | 1 | Input-register write strobe |
| wr_ch | input | CH_W | Channel index for the write |
| wr_data | input | DW | Code to write |
| busy | output | 1 | Combined busy indication, active high |
| busy_pull | output | 1 | Enable for the open-drain pull-down of the busy line |
| xfer_en | output | 1 | One-cycle enable copying input registers to DAC registers |
| gnd_sel | output | NUM_CH | Per-channel select: 1 = ground reference, 0 = DAC code |
| dac_code | output | NUM_CH*DW | DAC register contents, channel k at bits k*DW upward |

## Verification
The bench drives a five-channel, six-bit configuration with a three-bit write address, so out-of-range channels can be hit. It checks the exact cycle of the transfer pulse against the synchronizer depth. A design that drops a request arriving under internal or external busy would never update the codes. One that does not latch it at all would transfer early. The bench holds a request across a clear, and across a reset, and expects it to vanish. A design that keeps it would produce a transfer nobody asked for. It also releases clear without a load and expects the outputs to stay grounded. An implementation that ties the ground select straight to the clear level would fail that check. Codes written during clear must appear after the next load. One that clears registers on clear would load zeros instead.

// File: rtl/dac_ldctl_pkg.sv
// Package: shared types and helpers for the DAC load and clear controller.
// Assumes: nothing beyond IEEE 1800-2017 elaboration-time functions.
package dac_ldctl_pkg;

    // Asynchronous pin levels carried through the synchronizer as one word.
    typedef struct packed {
        logic ld_n;    // load strobe level
        logic clr_n;   // clear level
        logic line_n;  // shared busy line level
    } pin_lvl_t;

    localparam int PIN_W = $bits(pin_lvl_t);

    // Index width for a count of n items, at least one bit.
    function automatic int bits_for(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/dac_ldctl_sync.sv
// Module: dac_ldctl_sync
// Two-flop synchronizer for a vector of independent asynchronous levels.
// Each bit is synchronized on its own; no coherence between bits is implied.
// Assumes: each input level stays stable for at least two clock cycles.
module dac_ldctl_sync #(
    parameter int          WIDTH   = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic meta_q;
        logic stab_q;

        // Two-stage capture of one asynchronous bit, reset to its idle level.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[b];
                stab_q <= RST_VAL[b];
            end else begin
                meta_q <= d[b];
                stab_q <= meta_q;
            end
        end

        assign q[b] = stab_q;
    end

endmodule

// File: rtl/dac_ldctl_arb.sv
// Module: dac_ldctl_arb
// Arbitrates the synchronized load strobe against busy, clear and reset.
// Detects the falling edge of the strobe, holds a request while busy,
// runs the power-on window and issues a one-cycle transfer enable.
// Assumes: inputs already synchronized, POR_CYCLES >= 3 so a strobe held
// low through reset release falls inside the power-on window.
module dac_ldctl_arb #(
    parameter int POR_CYCLES = 16,
    localparam int POR_W     = dac_ldctl_pkg::bits_for(POR_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ld_lvl_n,   // synchronized load strobe
    input  logic clr_lvl_n,  // synchronized clear
    input  logic line_lvl_n, // synchronized shared busy line
    input  logic calc_busy,
    output logic busy,
    output logic busy_pull,
    output logic xfer_en,
    output logic clr_low,
    output logic por_active
);

    logic             ld_prev_q;
    logic             pending_q;
    logic             xfer_q;
    logic [POR_W-1:0] por_cnt_q;

    logic ld_fall;
    logic accept;
    logic want;
    logic issue;

    // Power-on window: counts down after reset release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            por_cnt_q <= POR_W'(POR_CYCLES);
        end else if (por_cnt_q != '0) begin
            por_cnt_q <= por_cnt_q - 1'b1;
        end
    end

    assign por_active = (por_cnt_q != '0);
    assign clr_low    = ~clr_lvl_n;

    // Busy sources: own drive covers calculation, reset and power-on.
    always_comb begin
        busy_pull = calc_busy | ~rst_n | por_active;
        busy      = busy_pull | ~line_lvl_n;
    end

    // Request path: edge detect, masking, hold and issue decision.
    always_comb begin
        ld_fall = ld_prev_q & ~ld_lvl_n;
        accept  = ld_fall & ~clr_low & ~por_active;
        want    = pending_q | accept;
        issue   = want & ~busy & ~clr_low;
    end

    // Previous strobe level for falling-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_prev_q <= 1'b1;
        end else begin
            ld_prev_q <= ld_lvl_n;
        end
    end

    // Held request: kept while busy, dropped by clear, reset or issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= 1'b0;
        end else begin
            pending_q <= want & ~issue & ~clr_low;
        end
    end

    // Registered one-cycle transfer enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xfer_q <= 1'b0;
        end else begin
            xfer_q <= issue;
        end
    end

    assign xfer_en = xfer_q;

endmodule

// File: rtl/dac_ldctl_bank.sv
// Module: dac_ldctl_bank
// Per-channel input register, DAC register and ground-select flop.
// Input registers take writes outside reset; DAC registers copy on the
// transfer enable; the ground select sets on clear and frees on transfer.
// Assumes: xfer_en is a single-cycle pulse from the arbiter.
module dac_ldctl_bank #(
    parameter int NUM_CH = 40,
    parameter int DW     = 14,
    localparam int CH_W  = dac_ldctl_pkg::bits_for(NUM_CH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [CH_W-1:0]      wr_ch,
    input  logic [DW-1:0]        wr_data,
    input  logic                 xfer_en,
    input  logic                 clr_low,
    output logic [NUM_CH*DW-1:0] in_flat,
    output logic [NUM_CH*DW-1:0] dac_flat,
    output logic [NUM_CH-1:0]    gnd_sel
);

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic [DW-1:0] in_q;
        logic [DW-1:0] dac_q;
        logic          gnd_q;
        logic          hit;

        assign hit = wr_en && (wr_ch == CH_W'(ch));

        // Input register: host writes, blocked only by reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                in_q <= '0;
            end else if (hit) begin
                in_q <= wr_data;
            end
        end

        // DAC register: copies the input register on a transfer.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dac_q <= '0;
            end else if (xfer_en) begin
                dac_q <= in_q;
            end
        end

        // Ground select: set by clear, held until the next transfer.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                gnd_q <= 1'b0;
            end else if (clr_low) begin
                gnd_q <= 1'b1;
            end else if (xfer_en) begin
                gnd_q <= 1'b0;
            end
        end

        assign in_flat[ch*DW +: DW]  = in_q;
        assign dac_flat[ch*DW +: DW] = dac_q;
        assign gnd_sel[ch]           = gnd_q;
    end

endmodule

// File: rtl/dac_load_ctrl.sv
// Module: dac_load_ctrl (top)
// Load and clear sequencing for a bank of DAC channels: synchronizes the
// asynchronous pins, arbitrates load requests against busy, clear and
// reset, and holds the per-channel input and DAC registers.
// Assumes: calc_busy is synchronous to clk; busy_line_n is the pin level
// of the shared open-drain line driven low by busy_pull and by others.
module dac_load_ctrl #(
    parameter int NUM_CH     = 40,
    parameter int DW         = 14,
    parameter int POR_CYCLES = 16,
    localparam int CH_W      = dac_ldctl_pkg::bits_for(NUM_CH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ldac_n,
    input  logic                 clr_n,
    input  logic                 calc_busy,
    input  logic                 busy_line_n,
    input  logic                 wr_en,
    input  logic [CH_W-1:0]      wr_ch,
    input  logic [DW-1:0]        wr_data,
    output logic                 busy,
    output logic                 busy_pull,
    output logic                 xfer_en,
    output logic [NUM_CH-1:0]    gnd_sel,
    output logic [NUM_CH*DW-1:0] dac_code
);

    import dac_ldctl_pkg::*;

    pin_lvl_t                pin_raw;
    pin_lvl_t                pin_syn;
    logic                    clr_low;
    logic                    por_active;
    logic [NUM_CH*DW-1:0]    in_flat;

    assign pin_raw = '{ld_n: ldac_n, clr_n: clr_n, line_n: busy_line_n};

    dac_ldctl_sync #(
        .WIDTH   (PIN_W),
        .RST_VAL ({PIN_W{1'b1}})
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_raw),
        .q     (pin_syn)
    );

    dac_ldctl_arb #(
        .POR_CYCLES (POR_CYCLES)
    ) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_lvl_n   (pin_syn.ld_n),
        .clr_lvl_n  (pin_syn.clr_n),
        .line_lvl_n (pin_syn.line_n),
        .calc_busy  (calc_busy),
        .busy       (busy),
        .busy_pull  (busy_pull),
        .xfer_en    (xfer_en),
        .clr_low    (clr_low),
        .por_active (por_active)
    );

    dac_ldctl_bank #(
        .NUM_CH (NUM_CH),
        .DW     (DW)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_ch    (wr_ch),
        .wr_data  (wr_data),
        .xfer_en  (xfer_en),
        .clr_low  (clr_low),
        .in_flat  (in_flat),
        .dac_flat (dac_code),
        .gnd_sel  (gnd_sel)
    );

endmodule

// File: rtl/dac_load_ctrl_chk.sv
// Module: dac_load_ctrl_chk
// Property checker for dac_load_ctrl, attached through bind below.
// Assumes: sampled on the block clock, disabled while reset is low.
module dac_load_ctrl_chk #(
    parameter int NUM_CH = 40,
    parameter int DW     = 14
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 busy,
    input logic                 xfer_en,
    input logic                 clr_low,
    input logic                 por_active,
    input logic [NUM_CH-1:0]    gnd_sel,
    input logic [NUM_CH*DW-1:0] dac_code,
    input logic [NUM_CH*DW-1:0] in_flat
);

    // R1
    xfer_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_en |=> !xfer_en);

    // R1
    xfer_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_en |=> (dac_code == $past(in_flat)));

    // R2
    xfer_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_en |-> !$past(busy));

    // R4
    por_no_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        por_active |=> !xfer_en);

    // R5
    clr_gnd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_low |=> (gnd_sel == '1) && !xfer_en);

    // R6
    gnd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gnd_sel[0]) |-> $past(xfer_en));

    // R7
    dac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_en |=> $stable(dac_code));

endmodule

bind dac_load_ctrl dac_load_ctrl_chk #(
    .NUM_CH (NUM_CH),
    .DW     (DW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .xfer_en    (xfer_en),
    .clr_low    (clr_low),
    .por_active (por_active),
    .gnd_sel    (gnd_sel),
    .dac_code   (dac_code),
    .in_flat    (in_flat)
);

// File: tb/test_dac_load_ctrl.sv
// Bench for dac_load_ctrl: small configuration, arithmetic code patterns,
// expected codes kept in a bench-side model of the input and DAC registers.
module test_dac_load_ctrl;

    localparam int NUM_CH = 5;
    localparam int DW     = 6;
    localparam int POR    = 4;
    localparam int CH_W   = 3;
    localparam int ADDRS  = 8;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic                 ldac_n;
    logic                 clr_n;
    logic                 calc_busy;
    logic                 busy_line_n;
    logic                 wr_en;
    logic [CH_W-1:0]      wr_ch;
    logic [DW-1:0]        wr_data;
    logic                 busy;
    logic                 busy_pull;
    logic                 xfer_en;
    logic [NUM_CH-1:0]    gnd_sel;
    logic [NUM_CH*DW-1:0] dac_code;

    int checks = 0;
    int errors = 0;
    int xfers  = 0;
    int base;
    logic [DW-1:0] exp_in  [NUM_CH];
    logic [DW-1:0] exp_dac [NUM_CH];

    always #4 clk = ~clk;

    dac_load_ctrl #(
        .NUM_CH     (NUM_CH),
        .DW         (DW),
        .POR_CYCLES (POR)
    ) i_dac_load_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .ldac_n      (ldac_n),
        .clr_n       (clr_n),
        .calc_busy   (calc_busy),
        .busy_line_n (busy_line_n),
        .wr_en       (wr_en),
        .wr_ch       (wr_ch),
        .wr_data     (wr_data),
        .busy        (busy),
        .busy_pull   (busy_pull),
        .xfer_en     (xfer_en),
        .gnd_sel     (gnd_sel),
        .dac_code    (dac_code)
    );

    // Count transfer pulses, sampled away from the active edge.
    always @(negedge clk) if (xfer_en === 1'b1) xfers++;

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_ch = CH_W'(a); wr_data = d;
        if (a < NUM_CH && rst_n) exp_in[a] = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_ld();
        @(negedge clk); ldac_n = 1'b0;
        cycles(3);
        ldac_n = 1'b1;
    endtask

    task automatic model_load();
        for (int c = 0; c < NUM_CH; c++) exp_dac[c] = exp_in[c];
    endtask

    task automatic chk_codes(input string tag);
        for (int c = 0; c < NUM_CH; c++)
            chk(dac_code[c*DW +: DW] == exp_dac[c], tag,
                32'(dac_code[c*DW +: DW]), 32'(exp_dac[c]));
    endtask

    task automatic write_pattern(input int p);
        for (int a = 0; a < ADDRS; a++) wr(a, DW'(a * 7 + p * 13 + 3));
    endtask

    // Watchdog: a hung run ends as a failure with the summary line.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; ldac_n = 1'b1; clr_n = 1'b1; calc_busy = 1'b0;
        busy_line_n = 1'b1; wr_en = 1'b0; wr_ch = '0; wr_data = '0;
        for (int c = 0; c < NUM_CH; c++) begin exp_in[c] = '0; exp_dac[c] = '0; end
        cycles(3);
        // R8: write during reset is ignored (model skips it).
        wr(1, 6'h2a);
        // R9 and R3: reset state.
        chk(busy && busy_pull, "R9 busy in reset", {busy, busy_pull}, 2'b11);
        chk(!xfer_en && gnd_sel == '0, "R9 outputs in reset", {xfer_en, gnd_sel}, 0);
        chk_codes("R9 codes in reset");

        // R4: load during the power-on window is discarded.
        @(negedge clk); rst_n = 1'b1; ldac_n = 1'b0;
        @(negedge clk);
        chk(busy && busy_pull, "R3 busy in power-on", {busy, busy_pull}, 2'b11);
        @(negedge clk); ldac_n = 1'b1;
        cycles(8);
        chk(!busy && !busy_pull, "R3 idle after power-on", {busy, busy_pull}, 0);
        chk(xfers == 0, "R4 power-on load dropped", xfers, 0);

        // R1 and R8: exact timing, reset-time write absent.
        base = xfers;
        @(negedge clk); ldac_n = 1'b0;
        cycles(2);
        chk(!xfer_en, "R1 no pulse before third edge", xfer_en, 0);
        cycles(1);
        chk(xfer_en, "R1 pulse after third edge", xfer_en, 1);
        cycles(1);
        chk(!xfer_en, "R1 pulse one cycle", xfer_en, 0);
        ldac_n = 1'b1;
        model_load();
        chk_codes("R8 reset write ignored");

        // R1, R8: sweep of patterns across all addresses.
        for (int p = 0; p < 4; p++) begin
            write_pattern(p);
            chk_codes("R1 no change before load");
            base = xfers;
            pulse_ld();
            cycles(4);
            model_load();
            chk(xfers == base + 1, "R1 one transfer", xfers - base, 1);
            chk_codes("R1 codes after load");
        end

        // R2 and R8: held request under internal busy.
        @(negedge clk); calc_busy = 1'b1;
        @(negedge clk);
        chk(busy && busy_pull, "R3 internal busy", {busy, busy_pull}, 2'b11);
        write_pattern(5);
        base = xfers;
        pulse_ld();
        cycles(8);
        chk(xfers == base, "R2 no transfer while busy", xfers - base, 0);
        chk_codes("R2 codes held while busy");
        calc_busy = 1'b0;
        @(negedge clk);
        chk(xfer_en, "R2 pulse right after busy drops", xfer_en, 1);
        cycles(2);
        model_load();
        chk(xfers == base + 1, "R2 single replay", xfers - base, 1);
        chk_codes("R8 busy-time writes loaded");

        // R3 and R2: external pull on the busy line.
        @(negedge clk); busy_line_n = 1'b0;
        cycles(3);
        chk(busy && !busy_pull, "R3 external busy", {busy, busy_pull}, 2'b10);
        write_pattern(6);
        base = xfers;
        pulse_ld();
        cycles(6);
        chk(xfers == base, "R2 external busy delays", xfers - base, 0);
        busy_line_n = 1'b1;
        cycles(6);
        model_load();
        chk(xfers == base + 1, "R2 replay after external", xfers - base, 1);
        chk_codes("R2 codes after external busy");

        // R5, R6, R7: clear behaviour.
        @(negedge clk); clr_n = 1'b0;
        cycles(4);
        chk(gnd_sel == '1, "R5 ground during clear", gnd_sel, {NUM_CH{1'b1}});
        chk_codes("R7 DAC codes kept in clear");
        write_pattern(9);
        base = xfers;
        pulse_ld();
        cycles(6);
        chk(xfers == base, "R5 load ignored in clear", xfers - base, 0);
        chk_codes("R5 codes unchanged in clear");
        clr_n = 1'b1;
        cycles(6);
        chk(gnd_sel == '1, "R6 ground held after clear", gnd_sel, {NUM_CH{1'b1}});
        pulse_ld();
        cycles(4);
        model_load();
        chk(gnd_sel == '0, "R6 ground freed by load", gnd_sel, 0);
        chk_codes("R7 clear-time writes loaded");

        // R5: held request dropped by clear.
        @(negedge clk); calc_busy = 1'b1;
        base = xfers;
        pulse_ld();
        cycles(3);
        clr_n = 1'b0;
        cycles(5);
        calc_busy = 1'b0;
        cycles(5);
        clr_n = 1'b1;
        cycles(8);
        chk(xfers == base, "R5 held request dropped", xfers - base, 0);
        chk(gnd_sel == '1, "R6 still grounded", gnd_sel, {NUM_CH{1'b1}});
        pulse_ld();
        cycles(4);
        chk(xfers == base + 1 && gnd_sel == '0, "R6 recovery load",
            {xfers - base, gnd_sel}, 1 << NUM_CH);

        // R4: held request lost across reset.
        @(negedge clk); calc_busy = 1'b1;
        base = xfers;
        pulse_ld();
        cycles(2);
        rst_n = 1'b0;
        cycles(3);
        calc_busy = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        for (int c = 0; c < NUM_CH; c++) begin exp_in[c] = '0; exp_dac[c] = '0; end
        cycles(POR + 8);
        chk(xfers == base, "R4 reset drops held request", xfers - base, 0);
        chk_codes("R9 codes after reset");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule